// File: doc/BRIEF.md
# Tracking Undervoltage Supervisor

This block watches a digitized regulator output and compares it with the commanded output level, less an offset picked by a two-bit code. It runs two such comparisons. The shallower one raises a warning flag at once. The deeper one raises a fault flag at once and also starts a qualification count. If the output stays low until that count runs out, the block acts on the power stage. It either holds both gate-drive enables off until the enable input is cycled, or it parks the stage for a fixed 56 ms and then asks the converter to start again. The retry loop repeats as often as the fault comes back.

Both voltages arrive as unsigned millivolt numbers, so the thresholds move with the setpoint. Monitoring is held off while soft-start is still running, while the converter is disabled, and while the block is latched or sleeping. Both status flags are sticky. Each is cleared by a strobe of its own.

Top module: `uv_track_sup`

## Requirements
- R1: The fault offset code `uvf_sel` selects 150 mV (0), 200 mV (1), 200 mV (2) or 300 mV (3) below `vset_mv`.
- R2: The warning offset code `uvw_sel` selects 100 mV (0), 150 mV (1), 200 mV (2) or 300 mV (3) below `vset_mv`.
- R3: A comparison counts as low only when `vout_mv + offset < vset_mv`. The values are unsigned millivolts, and equality is not low. A setpoint smaller than the offset never reads as low.
- R4: `uvw_flag` and `uvf_flag` are set on the second rising edge after the sample goes low. The warning path has no further delay.
- R5: With D = `DLY_BASE << dly_sel` cycles, an output that stays below the fault threshold from edge 1 takes the power stage out of run at edge 1+D.
- R6: If the sample rises above the fault threshold before the count expires, the count returns to zero. The next low period needs the full D again.
- R7: When the count expires with `restart` = 0, `hs_en` and `ls_en` both go low and stay low while `en` stays high. They return only after `en` has been seen low and then high again.
- R8: When the count expires with `restart` = 1, the drives go low for 56 × `CLK_PER_MS` cycles. Then `restart_req` pulses high for exactly one cycle and the drives turn back on. This repeats for every new fault, with no limit.
- R9: No flag is set and no count advances while `ss_done` is 0 or `en` is 0.
- R10: Each flag stays set until its clear strobe is given. A strobe given while its condition is still present is ignored.
- R11: After reset all outputs are 0. While running, `hs_en` and `ls_en` follow `en` one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| ss_done | input | 1 | Soft-start complete |
| vout_mv | input | MV_W | Sampled output voltage, mV |
| vset_mv | input | MV_W | Commanded output voltage, mV |
| uvf_sel | input | 2 | Fault offset code |
| uvw_sel | input | 2 | Warning offset code |
| dly_sel | input | 2 | Qualification length code |
| restart | input | 1 | 1 = hiccup retry, 0 = latch off |
| clr_uvf | input | 1 | Clear strobe for fault flag |
| clr_uvw | input | 1 | Clear strobe for warning flag |
| hs_en | output | 1 | High-side drive enable |
| ls_en | output | 1 | Low-side drive enable |
| restart_req | output | 1 | One-cycle start request after hiccup sleep |
| uvf_flag | output | 1 | Sticky undervoltage fault status |
| uvw_flag | output | 1 | Sticky undervoltage warning status |

## Verification
Some properties are checked on every cycle:
- Flags persist without a clear strobe.
- The restart request never lasts two cycles.
- Drives only turn on after `en` was high.
- A drive drop while enabled always comes with the fault flag already set.

The bench scenarios cover the rest:
- The threshold arithmetic at each offset code, including the equality boundary.
- The exact expiry cycle of the qualification count and its reset on recovery.
- The latch release through an enable toggle.
- The 56 ms sleep length and repeated retries.

// File: rtl/uv_track_pkg.sv
package uv_track_pkg;
  localparam int OFF_W = 9;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LATCH = 2'd1,
    ST_SLEEP = 2'd2
  } uv_state_e;

  // Fault offsets below setpoint, mV (R1)
  function automatic logic [OFF_W-1:0] fault_off(input logic [1:0] sel);
    case (sel)
      2'd0:       return 9'd150;
      2'd1, 2'd2: return 9'd200;
      default:    return 9'd300;
    endcase
  endfunction

  // Warning offsets below setpoint, mV (R2)
  function automatic logic [OFF_W-1:0] warn_off(input logic [1:0] sel);
    case (sel)
      2'd0:    return 9'd100;
      2'd1:    return 9'd150;
      2'd2:    return 9'd200;
      default: return 9'd300;
    endcase
  endfunction
endpackage

// File: rtl/uv_cmp.sv
module uv_cmp
  import uv_track_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mon,
  input  logic [MV_W-1:0] vout_mv,
  input  logic [MV_W-1:0] vset_mv,
  input  logic [1:0]      uvf_sel,
  input  logic [1:0]      uvw_sel,
  output logic            below_f,
  output logic            below_w
);
  localparam int SUM_W = MV_W + 1;

  logic [SUM_W-1:0] vset_x, f_sum, w_sum;

  // R3: sample + offset < setpoint, one extra bit so no wrap
  always_comb begin
    vset_x = {1'b0, vset_mv};
    f_sum  = {1'b0, vout_mv} + SUM_W'(fault_off(uvf_sel));
    w_sum  = {1'b0, vout_mv} + SUM_W'(warn_off(uvw_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      below_f <= 1'b0;
      below_w <= 1'b0;
    end else begin
      below_f <= mon && (f_sum < vset_x);
      below_w <= mon && (w_sum < vset_x);
    end
  end
endmodule

// File: rtl/uv_sticky.sv
module uv_sticky (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  // R10: set wins; clear only when condition is gone
  always_ff @(posedge clk) begin
    if (rst)             flag <= 1'b0;
    else if (hit)        flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end
endmodule

// File: rtl/uv_qual.sv
module uv_qual #(
  parameter int DLY_BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       below,
  input  logic [1:0] dly_sel,
  output logic       expire
);
  localparam int CNT_W = $clog2(DLY_BASE * 8 + 1);

  logic [CNT_W-1:0] cnt, limit;

  always_comb begin
    limit  = CNT_W'((DLY_BASE << dly_sel) - 1);
    expire = below && (cnt == limit);
  end

  // R6: any recovery restarts the count from zero
  always_ff @(posedge clk) begin
    if (rst || !below || expire) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uv_resp.sv
module uv_resp
  import uv_track_pkg::*;
#(
  parameter int CLK_PER_MS = 250000,
  parameter int SLEEP_MS   = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic expire,
  input  logic restart,
  output logic run,
  output logic hs_en,
  output logic ls_en,
  output logic restart_req
);
  localparam int PRE_W = $clog2(CLK_PER_MS + 1);
  localparam int MS_W  = $clog2(SLEEP_MS + 1);

  uv_state_e        st, st_d;
  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms;
  logic             pre_wrap, sleep_done;

  always_comb begin
    pre_wrap   = (pre == PRE_W'(CLK_PER_MS - 1));
    sleep_done = pre_wrap && (ms == MS_W'(SLEEP_MS - 1));
    st_d       = st;
    case (st)
      ST_RUN:   if (expire) st_d = restart ? ST_SLEEP : ST_LATCH;
      ST_LATCH: if (!en) st_d = ST_RUN;
      ST_SLEEP: if (!en || sleep_done) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      pre         <= '0;
      ms          <= '0;
      hs_en       <= 1'b0;
      ls_en       <= 1'b0;
      restart_req <= 1'b0;
    end else begin
      st          <= st_d;
      hs_en       <= (st_d == ST_RUN) && en;
      ls_en       <= (st_d == ST_RUN) && en;
      restart_req <= (st == ST_SLEEP) && en && sleep_done;
      if (st == ST_SLEEP) begin
        pre <= pre_wrap ? '0 : pre + 1'b1;
        if (pre_wrap) ms <= ms + 1'b1;
      end else begin
        pre <= '0;
        ms  <= '0;
      end
    end
  end

  assign run = (st == ST_RUN);
endmodule

// File: rtl/uv_track_sup.sv
module uv_track_sup
  import uv_track_pkg::*;
#(
  parameter int MV_W       = 16,
  parameter int CLK_PER_MS = 250000,
  parameter int SLEEP_MS   = 56,
  parameter int DLY_BASE   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            ss_done,
  input  logic [MV_W-1:0] vout_mv,
  input  logic [MV_W-1:0] vset_mv,
  input  logic [1:0]      uvf_sel,
  input  logic [1:0]      uvw_sel,
  input  logic [1:0]      dly_sel,
  input  logic            restart,
  input  logic            clr_uvf,
  input  logic            clr_uvw,
  output logic            hs_en,
  output logic            ls_en,
  output logic            restart_req,
  output logic            uvf_flag,
  output logic            uvw_flag
);
  localparam int N_FLAG = 2;

  logic              run, mon, below_f, below_w, expire;
  logic [N_FLAG-1:0] hit, clr, flag;

  // R9: monitor only when enabled, soft-started and running
  assign mon = ss_done && en && run;

  uv_cmp #(.MV_W(MV_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .mon     (mon),
    .vout_mv (vout_mv),
    .vset_mv (vset_mv),
    .uvf_sel (uvf_sel),
    .uvw_sel (uvw_sel),
    .below_f (below_f),
    .below_w (below_w)
  );

  assign hit = {below_w, below_f};
  assign clr = {clr_uvw, clr_uvf};

  generate
    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      uv_sticky u_flag (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit[i]),
        .clr  (clr[i]),
        .flag (flag[i])
      );
    end
  endgenerate

  assign uvf_flag = flag[0];
  assign uvw_flag = flag[1];

  uv_qual #(.DLY_BASE(DLY_BASE)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .below   (below_f),
    .dly_sel (dly_sel),
    .expire  (expire)
  );

  uv_resp #(.CLK_PER_MS(CLK_PER_MS), .SLEEP_MS(SLEEP_MS)) u_resp (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .expire      (expire),
    .restart     (restart),
    .run         (run),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .restart_req (restart_req)
  );
endmodule

// File: rtl/uv_track_chk.sv
module uv_track_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic clr_uvf,
  input logic clr_uvw,
  input logic hs_en,
  input logic ls_en,
  input logic restart_req,
  input logic uvf_flag,
  input logic uvw_flag
);
  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req);

  assert_uvf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (uvf_flag && !clr_uvf) |=> uvf_flag);

  assert_uvw_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (uvw_flag && !clr_uvw) |=> uvw_flag);

  assert_drv_needs_en_R11: assert property (@(posedge clk) disable iff (rst)
    (hs_en || ls_en) |-> $past(en));

  assert_trip_has_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_en) && $past(en)) |-> uvf_flag);
endmodule

bind uv_track_sup uv_track_chk u_chk (.*);

// File: tb/uv_track_sup_tb.sv
module uv_track_sup_tb;
  localparam int MV_W = 16;
  localparam int CPM  = 4;
  localparam int SMS  = 56;
  localparam int DB   = 4;
  localparam int NV   = 13;

  logic clk = 1'b0;
  logic rst, en, ss_done, restart, clr_uvf, clr_uvw;
  logic [MV_W-1:0] vout_mv, vset_mv;
  logic [1:0] uvf_sel, uvw_sel, dly_sel;
  logic hs_en, ls_en, restart_req, uvf_flag, uvw_flag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uv_track_sup #(.MV_W(MV_W), .CLK_PER_MS(CPM), .SLEEP_MS(SMS), .DLY_BASE(DB)) u_dut (
    .clk(clk), .rst(rst), .en(en), .ss_done(ss_done),
    .vout_mv(vout_mv), .vset_mv(vset_mv),
    .uvf_sel(uvf_sel), .uvw_sel(uvw_sel), .dly_sel(dly_sel),
    .restart(restart), .clr_uvf(clr_uvf), .clr_uvw(clr_uvw),
    .hs_en(hs_en), .ls_en(ls_en), .restart_req(restart_req),
    .uvf_flag(uvf_flag), .uvw_flag(uvw_flag)
  );

  // {vset, vout, uvf_sel, uvw_sel, exp_fault, exp_warn}
  localparam logic [37:0] VEC [NV] = '{
    {16'd1000, 16'd850, 2'd0, 2'd0, 1'b0, 1'b1},
    {16'd1000, 16'd849, 2'd0, 2'd0, 1'b1, 1'b1},
    {16'd1000, 16'd900, 2'd0, 2'd0, 1'b0, 1'b0},
    {16'd1000, 16'd899, 2'd0, 2'd0, 1'b0, 1'b1},
    {16'd1000, 16'd800, 2'd1, 2'd1, 1'b0, 1'b1},
    {16'd1000, 16'd799, 2'd2, 2'd2, 1'b1, 1'b1},
    {16'd1000, 16'd800, 2'd2, 2'd2, 1'b0, 1'b0},
    {16'd1000, 16'd700, 2'd3, 2'd3, 1'b0, 1'b0},
    {16'd1000, 16'd699, 2'd3, 2'd3, 1'b1, 1'b1},
    {16'd1000, 16'd850, 2'd1, 2'd0, 1'b0, 1'b1},
    {16'd100,  16'd0,   2'd0, 2'd0, 1'b0, 1'b0},
    {16'd1800, 16'd1649, 2'd0, 2'd3, 1'b1, 1'b0},
    {16'd600,  16'd499, 2'd2, 2'd0, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    clr_uvf = 1'b1; clr_uvw = 1'b1;
    step(1);
    clr_uvf = 1'b0; clr_uvw = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; ss_done = 1'b0; restart = 1'b0;
    clr_uvf = 1'b0; clr_uvw = 1'b0;
    vout_mv = 16'd1000; vset_mv = 16'd1000;
    uvf_sel = 2'd0; uvw_sel = 2'd0; dly_sel = 2'd0;
    step(3);
    // R11 reset state
    check("R11 hs_en reset", {31'd0, hs_en}, 32'd0);
    check("R11 ls_en reset", {31'd0, ls_en}, 32'd0);
    check("R11 flags reset", {30'd0, uvf_flag, uvw_flag}, 32'd0);
    check("R11 restart_req reset", {31'd0, restart_req}, 32'd0);
    rst = 1'b0;
    en  = 1'b1;
    step(1);
    check("R11 drives follow en", {30'd0, hs_en, ls_en}, 32'd3);

    // R9: soft-start not done, output collapsed
    vout_mv = 16'd0;
    step(20);
    check("R9 no flags before ss_done", {30'd0, uvf_flag, uvw_flag}, 32'd0);
    check("R9 drives stay on before ss_done", {30'd0, hs_en, ls_en}, 32'd3);
    vout_mv = 16'd1000;
    step(1);
    ss_done = 1'b1;
    dly_sel = 2'd3;
    step(2);

    // R1 R2 R3 threshold table
    for (int i = 0; i < NV; i++) begin
      vset_mv = VEC[i][37:22];
      vout_mv = VEC[i][21:6];
      uvf_sel = VEC[i][5:4];
      uvw_sel = VEC[i][3:2];
      step(2);
      check($sformatf("R1 R3 R4 fault flag vec %0d", i), {31'd0, uvf_flag}, {31'd0, VEC[i][1]});
      check($sformatf("R2 R3 R4 warn flag vec %0d", i), {31'd0, uvw_flag}, {31'd0, VEC[i][0]});
      vout_mv = vset_mv;
      step(2);
      clear_flags();
      step(1);
      check($sformatf("R10 flags cleared vec %0d", i), {30'd0, uvf_flag, uvw_flag}, 32'd0);
    end

    // R10 clear ignored while still low
    vset_mv = 16'd1000; uvf_sel = 2'd0; uvw_sel = 2'd0;
    vout_mv = 16'd849;
    step(2);
    clear_flags();
    check("R10 clear ignored while low", {30'd0, uvf_flag, uvw_flag}, 32'd3);
    vout_mv = 16'd1000;
    step(2);
    clear_flags();
    check("R10 clear after recovery", {30'd0, uvf_flag, uvw_flag}, 32'd0);

    // R6 counter restarts on recovery (D = 8)
    dly_sel = 2'd1;
    restart = 1'b0;
    vout_mv = 16'd700;
    step(6);
    vout_mv = 16'd1000;
    step(3);
    vout_mv = 16'd700;
    step(6);
    vout_mv = 16'd1000;
    step(3);
    check("R6 no trip after split low periods", {30'd0, hs_en, ls_en}, 32'd3);

    // R5 exact expiry, R7 latch
    vout_mv = 16'd700;
    step(8);
    check("R5 drives on at edge D", {30'd0, hs_en, ls_en}, 32'd3);
    step(1);
    check("R5 R7 drives off at edge D+1", {30'd0, hs_en, ls_en}, 32'd0);
    vout_mv = 16'd1000;
    step(20);
    check("R7 latched while en high", {30'd0, hs_en, ls_en}, 32'd0);
    check("R7 no restart request in latch", {31'd0, restart_req}, 32'd0);
    en = 1'b0;
    step(1);
    en = 1'b1;
    step(1);
    check("R7 drives back after en toggle", {30'd0, hs_en, ls_en}, 32'd3);
    clear_flags();

    // R8 hiccup (D = 4, sleep = 224)
    dly_sel = 2'd0;
    restart = 1'b1;
    step(2);
    vout_mv = 16'd700;
    step(5);
    check("R8 drives off after trip", {30'd0, hs_en, ls_en}, 32'd0);
    step(223);
    check("R8 request low before sleep end", {31'd0, restart_req}, 32'd0);
    check("R8 drives off before sleep end", {30'd0, hs_en, ls_en}, 32'd0);
    step(1);
    check("R8 request at sleep end", {31'd0, restart_req}, 32'd1);
    check("R8 drives on at sleep end", {30'd0, hs_en, ls_en}, 32'd3);
    step(1);
    check("R8 request lasts one cycle", {31'd0, restart_req}, 32'd0);
    begin
      int pulses = 0;
      for (int k = 0; k < 460; k++) begin
        step(1);
        if (restart_req) pulses++;
      end
      check("R8 unlimited retries", pulses, 32'd2);
    end
    check("R8 fault flag kept", {31'd0, uvf_flag}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule